// File: doc/BRIEF.md
# Push-Out Shared Cell Buffer Admission Manager

This block decides, cycle by cycle, whether a cell arriving at a shared buffer is admitted, and which queue gives up a cell when the buffer has no free slot. The buffer holds a fixed number of cells shared by several output queues. The block keeps a length counter for each queue and one occupancy counter for the whole buffer. It does not store cell data or maintain queue links. A controller that does maintain them follows the block's accept and push-out outputs.

While a free slot exists, every arrival is taken. When the buffer is full, the arrival is not refused. The block takes it in and evicts one cell from the tail of the longest queue. Ties go to the lowest-numbered queue. If the arriving cell's own queue is already as long as the longest candidate, the arrival itself is dropped instead.

A threshold mode, selected at run time, limits eviction to queues whose length is above a per-queue threshold. If no queue qualifies, the arrival is dropped. Dequeues in the same cycle are applied first, so a slot freed by a departure can be used by an arrival in that same cycle.

Top module: `pobm_pushout_mgr`

## Requirements
- R1: After synchronous reset every queue length and the occupancy read 0, and `accept` and `push_valid` are 0 while no arrival is offered.
- R2: An offered arrival is accepted with `push_valid`=0 when the occupancy after this cycle's dequeues is below CAP. On the next clock edge its queue's length and the occupancy each rise by one.
- R3: A dequeue pulse on a non-empty queue lowers that queue's length and the occupancy by one at the next edge. A dequeue pulse on an empty queue changes no length and no occupancy.
- R4: Dequeues in the same cycle are counted before admission. A buffer that was full but loses a cell this cycle accepts an arrival without push-out.
- R5: When the occupancy after dequeues equals CAP and eviction is allowed, `accept`=1, `push_valid`=1 and `push_port` names the longest eligible queue, all in the same cycle. At the next edge the victim loses one cell, the arrival's queue gains one, and the occupancy is unchanged.
- R6: Among equally long eligible queues, the victim is the one with the lowest index.
- R7: With the buffer full, an arrival whose own queue length is at least that of the longest eligible queue is dropped: `accept`=0, `push_valid`=0, and no length changes apart from dequeues.
- R8: With `thr_en`=1, a queue is eligible for eviction only if its length after dequeues is strictly greater than its threshold field in `thr_lvl`. Field i occupies bits [i*CW +: CW], where CW=$clog2(CAP+1). With the buffer full and no queue eligible, the arrival is dropped.
- R9: With `thr_en`=0, every queue is eligible. The victim is the arrival's own queue never, because of R7.
- R10: The occupancy always equals the sum of all queue lengths and never exceeds CAP.
- R11: With `arr_valid`=0, `accept` and `push_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_port | input | PW | Destination queue of the arrival |
| deq | input | N_Q | One dequeue pulse per queue |
| thr_en | input | 1 | Selects threshold-limited eviction |
| thr_lvl | input | N_Q*CW | Per-queue eviction thresholds, queue i at [i*CW +: CW] |
| accept | output | 1 | The arrival is admitted |
| push_valid | output | 1 | A cell is evicted this cycle |
| push_port | output | PW | Queue that loses its tail cell (0 when no eviction) |
| qlen | output | N_Q*CW | Registered queue lengths, queue i at [i*CW +: CW] |
| occupancy | output | CW | Registered total cell count |

## Verification
`accept`, `push_valid` and `push_port` are combinational. They depend on this cycle's inputs and the registered counters, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and samples these outputs one nanosecond later. Queue lengths and occupancy pass through one register, so they are due after the next rising edge, and the bench samples them one nanosecond past that edge. A bench model applies the dequeue-first, longest-queue, lowest-index, own-queue and threshold rules to predict both sets of values.

// File: rtl/pobm_pkg.sv
package pobm_pkg;

    // Outcome of the admission decision for one cycle
    typedef enum logic [1:0] {
        ADM_IDLE  = 2'd0,
        ADM_TAKE  = 2'd1,
        ADM_EVICT = 2'd2,
        ADM_DROP  = 2'd3
    } adm_e;

    // Returns 1 when an arrival either takes a slot or evicts a cell
    function automatic logic adm_admits(input adm_e d);
        return (d == ADM_TAKE) || (d == ADM_EVICT);
    endfunction

endpackage

// File: rtl/pobm_qcount.sv
module pobm_qcount #(
    parameter int CAP = 16,
    parameter int CW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deq_req,
    input  logic          add,
    input  logic          drop,
    output logic [CW-1:0] len,
    output logic [CW-1:0] post_len,
    output logic          deq_eff
);
    logic [CW-1:0] len_r;

    assign deq_eff  = deq_req && (len_r != '0);
    assign post_len = len_r - {{(CW-1){1'b0}}, deq_eff};
    assign len      = len_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_r <= '0;
        end else begin
            len_r <= post_len + {{(CW-1){1'b0}}, add} - {{(CW-1){1'b0}}, drop};
        end
    end

    // R5
    evict_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        drop |-> (post_len != '0));

    // R10
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        len_r <= CW'(CAP));

endmodule

// File: rtl/pobm_longest.sv
module pobm_longest #(
    parameter int N_Q = 4,
    parameter int CW  = 5,
    parameter int PW  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_Q-1:0][CW-1:0] lens,
    input  logic [N_Q-1:0]         elig,
    output logic                   found,
    output logic [PW-1:0]          idx,
    output logic [CW-1:0]          max_len
);
    always_comb begin
        found   = 1'b0;
        idx     = '0;
        max_len = '0;
        for (int i = 0; i < N_Q; i++) begin
            // strict compare keeps the lowest index on ties
            if (elig[i] && (!found || lens[i] > max_len)) begin
                found   = 1'b1;
                idx     = PW'(i);
                max_len = lens[i];
            end
        end
    end

    // R8
    pick_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> elig[idx]);

    // R6
    pick_length_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (lens[idx] == max_len));

endmodule

// File: rtl/pobm_pushout_mgr.sv
module pobm_pushout_mgr
    import pobm_pkg::*;
#(
    parameter int N_Q = 4,
    parameter int CAP = 16,
    localparam int PW = (N_Q > 1) ? $clog2(N_Q) : 1,
    localparam int CW = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arr_valid,
    input  logic [PW-1:0]     arr_port,
    input  logic [N_Q-1:0]    deq,
    input  logic              thr_en,
    input  logic [N_Q*CW-1:0] thr_lvl,
    output logic              accept,
    output logic              push_valid,
    output logic [PW-1:0]     push_port,
    output logic [N_Q*CW-1:0] qlen,
    output logic [CW-1:0]     occupancy
);
    logic [N_Q-1:0][CW-1:0] len_q;
    logic [N_Q-1:0][CW-1:0] post_q;
    logic [N_Q-1:0]         deq_eff;
    logic [N_Q-1:0]         elig;
    logic [N_Q-1:0]         add_q;
    logic [N_Q-1:0]         drop_q;
    logic [CW-1:0]          occ_r;
    logic [CW-1:0]          n_deq;
    logic [CW-1:0]          post_occ;
    logic [CW-1:0]          own_len;
    logic                   cand_found;
    logic [PW-1:0]          cand_idx;
    logic [CW-1:0]          cand_len;
    adm_e                   dec;

    // per-queue counters and eligibility
    for (genvar g = 0; g < N_Q; g++) begin : g_q
        pobm_qcount #(.CAP(CAP), .CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .deq_req  (deq[g]),
            .add      (add_q[g]),
            .drop     (drop_q[g]),
            .len      (len_q[g]),
            .post_len (post_q[g]),
            .deq_eff  (deq_eff[g])
        );
        assign elig[g]           = !thr_en || (post_q[g] > thr_lvl[g*CW +: CW]);
        assign add_q[g]          = adm_admits(dec) && (arr_port == PW'(g));
        assign drop_q[g]         = (dec == ADM_EVICT) && (cand_idx == PW'(g));
        assign qlen[g*CW +: CW]  = len_q[g];
    end

    pobm_longest #(.N_Q(N_Q), .CW(CW), .PW(PW)) u_max (
        .clk     (clk),
        .rst     (rst),
        .lens    (post_q),
        .elig    (elig),
        .found   (cand_found),
        .idx     (cand_idx),
        .max_len (cand_len)
    );

    always_comb begin
        n_deq = '0;
        for (int i = 0; i < N_Q; i++) begin
            n_deq = n_deq + {{(CW-1){1'b0}}, deq_eff[i]};
        end
        post_occ = occ_r - n_deq;
        own_len  = post_q[arr_port];
    end

    always_comb begin
        if (!arr_valid) begin
            dec = ADM_IDLE;
        end else if (post_occ < CW'(CAP)) begin
            dec = ADM_TAKE;
        end else if (!cand_found || own_len >= cand_len) begin
            dec = ADM_DROP;
        end else begin
            dec = ADM_EVICT;
        end
    end

    assign accept     = adm_admits(dec);
    assign push_valid = (dec == ADM_EVICT);
    assign push_port  = push_valid ? cand_idx : '0;
    assign occupancy  = occ_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_r <= '0;
        end else begin
            occ_r <= post_occ + {{(CW-1){1'b0}}, (dec == ADM_TAKE)};
        end
    end

    // independent sum of queue lengths for the consistency check
    logic [CW+PW:0] len_sum;
    always_comb begin
        len_sum = '0;
        for (int i = 0; i < N_Q; i++) begin
            len_sum = len_sum + (CW+PW+1)'(len_q[i]);
        end
    end

    // R10
    occ_sum_chk: assert property (@(posedge clk) disable iff (rst)
        len_sum == (CW+PW+1)'(occ_r));

    // R10
    occ_cap_chk: assert property (@(posedge clk) disable iff (rst)
        occ_r <= CW'(CAP));

    // R2
    free_slot_take_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && occ_r < CW'(CAP)) |-> (accept && !push_valid));

    // R9
    no_self_evict_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> (push_port != arr_port));

    // R5
    evict_keeps_occ_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> (occ_r == $past(occ_r)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !arr_valid |-> (!accept && !push_valid));

endmodule

// File: tb/tb_pobm_pushout_mgr.sv
module tb_pobm_pushout_mgr;
    localparam int N_Q = 4;
    localparam int CAP = 16;
    localparam int PW  = 2;
    localparam int CW  = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              arr_valid;
    logic [PW-1:0]     arr_port;
    logic [N_Q-1:0]    deq;
    logic              thr_en;
    logic [N_Q*CW-1:0] thr_lvl;
    logic              accept;
    logic              push_valid;
    logic [PW-1:0]     push_port;
    logic [N_Q*CW-1:0] qlen;
    logic [CW-1:0]     occupancy;

    int n_chk  = 0;
    int n_fail = 0;
    int mlen[N_Q];
    int mocc;

    always #2 clk = ~clk;

    pobm_pushout_mgr #(.N_Q(N_Q), .CAP(CAP)) dut (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_port(arr_port),
        .deq(deq), .thr_en(thr_en), .thr_lvl(thr_lvl), .accept(accept),
        .push_valid(push_valid), .push_port(push_port), .qlen(qlen),
        .occupancy(occupancy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input int q);
        return int'(thr_lvl[q*CW +: CW]);
    endfunction

    task automatic check_state();
        for (int q = 0; q < N_Q; q++) chk("R3 qlen", int'(qlen[q*CW +: CW]), mlen[q]);
        chk("R10 occupancy", int'(occupancy), mocc);
    endtask

    // one cycle: drive, check same-cycle decision, update model, check registers
    task automatic step(input logic v, input int p, input logic [N_Q-1:0] d);
        int post[N_Q];
        int pocc, best, blen, nmax, e_acc, e_push;
        string tag;
        @(negedge clk);
        arr_valid = v; arr_port = PW'(p); deq = d;
        #1;
        pocc = mocc;
        for (int q = 0; q < N_Q; q++) begin
            post[q] = mlen[q];
            if (d[q] && mlen[q] > 0) begin post[q]--; pocc--; end
        end
        best = -1; blen = 0; nmax = 0;
        for (int q = 0; q < N_Q; q++) begin
            if (!thr_en || post[q] > thr_of(q)) begin
                if (best < 0 || post[q] > blen) begin best = q; blen = post[q]; end
            end
        end
        for (int q = 0; q < N_Q; q++)
            if (best >= 0 && (!thr_en || post[q] > thr_of(q)) && post[q] == blen) nmax++;
        e_acc = 0; e_push = 0;
        if (!v) tag = "R11";
        else if (pocc < CAP) begin
            e_acc = 1;
            tag = (pocc < mocc && mocc == CAP) ? "R4" : "R2";
        end else if (best < 0) tag = "R8";
        else if (post[p] >= blen) tag = thr_en ? "R8" : "R7";
        else begin
            e_acc = 1; e_push = 1;
            tag = (nmax > 1) ? "R6" : (thr_en ? "R8" : "R5");
        end
        chk({tag, " accept"}, int'(accept), e_acc);
        chk({tag, " push_valid"}, int'(push_valid), e_push);
        if (e_push == 1) chk({tag, " R9 push_port"}, int'(push_port), best);
        for (int q = 0; q < N_Q; q++) mlen[q] = post[q];
        mocc = pocc;
        if (e_acc == 1) begin
            mlen[p]++;
            if (e_push == 1) mlen[best]--; else mocc++;
        end
        @(posedge clk); #1;
        check_state();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; arr_valid = 1'b0; arr_port = '0; deq = '0;
        thr_en = 1'b0; thr_lvl = '0;
        for (int q = 0; q < N_Q; q++) mlen[q] = 0;
        mocc = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int q = 0; q < N_Q; q++) chk("R1 qlen", int'(qlen[q*CW +: CW]), 0);
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 accept", int'(accept), 0);
        chk("R1 push_valid", int'(push_valid), 0);
        @(negedge clk); rst = 1'b0;

        // R3 dequeue of empty queue ignored
        step(1'b0, 0, 4'b1111);
        // R2 fill to capacity: q0=6, q1=6, q2=4
        for (int k = 0; k < 6; k++) step(1'b1, 0, 4'b0000);
        for (int k = 0; k < 6; k++) step(1'b1, 1, 4'b0000);
        for (int k = 0; k < 4; k++) step(1'b1, 2, 4'b0000);
        // R6 tie q0/q1, victim q0
        step(1'b1, 3, 4'b0000);
        // R7 own queue q1 is longest
        step(1'b1, 1, 4'b0000);
        // R4 dequeue frees slot this cycle
        step(1'b1, 2, 4'b0010);
        // R8 thresholds above every length: drop
        thr_en = 1'b1;
        for (int q = 0; q < N_Q; q++) thr_lvl[q*CW +: CW] = CW'(15);
        step(1'b1, 3, 4'b0000);
        // R8 only q2 eligible
        thr_lvl[2*CW +: CW] = CW'(2);
        step(1'b1, 0, 4'b0000);
        thr_en = 1'b0;

        // constrained random phases
        for (int n = 0; n < 3000; n++) begin
            logic [N_Q-1:0] dd;
            if (n % 500 == 0) begin
                thr_en = (n >= 1500);
                for (int q = 0; q < N_Q; q++) thr_lvl[q*CW +: CW] = CW'($urandom % 9);
            end
            dd = '0;
            for (int q = 0; q < N_Q; q++) dd[q] = (($urandom % 8) == 0);
            step(($urandom % 10) < 8, int'($urandom % N_Q), dd);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule